// File: doc/BRIEF.md
# Programmable Watchdog Timer with Expiry Steering

This block is a watchdog timer that software programs through one byte-wide control register. The control byte holds three fields. A 2-bit resolution code `RES` sits in bits 1:0. A 5-bit multiplier `M` sits in bits 6:2. A steering bit sits in bit 7. The timeout is `M << (2*RES)` periods of a 1/16-second tick. A built-in divider derives that tick from the system clock: one tick every `TICK_DIV` clock cycles.

Software keeps the watchdog alive by writing or reading the control register, and either access restarts the countdown. If the countdown runs out, the block latches a sticky timeout flag. What happens next depends on the steering bit:
- Steering bit clear: the block emits a one-cycle interrupt pulse and then stays idle.
- Steering bit set: the block drives a system reset output for a fixed number of cycles, clears the control register, and clears the century bit held in a small auxiliary register.

The block has a simple byte register interface with a 2-bit address:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read-only; timeout flag in bit 7 |
| 2 | auxiliary | only bit 6 (century bit) is stored |
| 3 | none | reads as zero |

Top module: `wdog_steer`

## Requirements
- R1: After synchronous reset the control register reads 0x00, the status register reads 0x00, the auxiliary register reads 0x00, and `wd_irq` and `sys_rst_o` are low. No expiry follows unless software writes a nonzero interval.
- R2: A control write of value V arms the timer with N = V[6:2] << (2*V[1:0]) ticks, where one tick is `TICK_DIV` clock cycles. The timeout flag rises on the clock edge exactly N*`TICK_DIV` cycles after the edge that took the write.
- R3: A control value whose interval N is zero (V[6:2] == 0, including V = 0x00) leaves the watchdog disabled, and no expiry ever occurs.
- R4: Every control write clears the timeout flag and restarts the count from the newly written value.
- R5: A read of the control register (address 0) returns the stored value unchanged, and restarts the full count from that stored value.
- R6: On expiry the timeout flag (`wd_timeout`, and status bit 7 at address 1) is set. It stays set until the next control write.
- R7: When bit 7 of the control value is 0, expiry produces a single one-cycle `wd_irq` pulse and leaves `sys_rst_o` low. The count then stays stopped, with no further pulse, until a read or write re-arms it.
- R8: When bit 7 of the control value is 1, expiry drives `sys_rst_o` high for exactly `RST_HOLD` cycles, starting on the expiry edge. It also clears the control register to 0x00 and clears auxiliary bit 6. No `wd_irq` pulse is produced.
- R9: Writes to the status register (address 1) have no effect. The auxiliary register (address 2) keeps only bit 6 of a written byte, and all its other bits read 0.
- R10: If a control write arrives in the same cycle in which the count would expire, the write wins. The flag stays clear, no pulse or reset occurs, and the new count starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 auxiliary |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| wd_timeout | output | 1 | Sticky timeout flag |
| wd_irq | output | 1 | One-cycle interrupt pulse on interrupt-mode expiry |
| sys_rst_o | output | 1 | System reset request, held `RST_HOLD` cycles |

## Verification
The bench uses a small tick divider. It measures expiry to the exact cycle for several resolution and multiplier combinations, including the largest interval, 0x7F, where an undersized counter or a wrong shift would expire early. It checks the zero-interval encodings and the restart-by-read path. A design that ignored read restarts, or reloaded a wrong value on a read, would expire at the wrong cycle. The bench also targets a write that lands on the expiry cycle, where a design that lets the expiry win would raise the flag. In reset mode it counts the exact reset width and checks that the control register and the century bit were cleared and that no interrupt leaked out.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int RES_W  = 2;
   localparam int MULT_W = 5;
   localparam int CTL_W  = 1 + MULT_W + RES_W;
   // Largest interval is mult << (2 * (2**RES_W - 1)).
   localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);

   typedef struct packed {
      logic              steer;
      logic [MULT_W-1:0] mult;
      logic [RES_W-1:0]  res;
   } wdog_ctl_t;

   typedef enum logic [1:0] {
      REG_CTL  = 2'd0,
      REG_STAT = 2'd1,
      REG_AUX  = 2'd2,
      REG_NONE = 2'd3
   } wdog_reg_e;

   function automatic logic [CNT_W-1:0] ticks_of(input wdog_ctl_t c);
      logic [CNT_W-1:0] base;
      base = CNT_W'(c.mult);
      return base << (2 * c.res);
   endfunction
endpackage

// File: rtl/wdog_tick_div.sv
module wdog_tick_div #(
   parameter int DIV = 15_625_000
) (
   input  logic clk,
   input  logic rst,
   input  logic restart,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad
         $error("wdog_tick_div: DIV must be at least 1");
      end else if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_cnt
         logic [PW-1:0] presc;
         always_ff @(posedge clk) begin
            if (rst || restart || tick) presc <= '0;
            else                        presc <= presc + 1'b1;
         end
         assign tick = (presc == PW'(DIV - 1));

         // R2: a restart realigns the tick phase, so no tick right after it
         a_r2_tick_realign: assert property (@(posedge clk) disable iff (rst)
            restart |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
   import wdog_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_ticks,
   input  logic             tick,
   output logic             expire
);
   logic             armed;
   logic [CNT_W-1:0] remain;

   assign expire = armed && tick && (remain == CNT_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed  <= 1'b0;
         remain <= '0;
      end else if (load) begin
         armed  <= (load_ticks != '0);
         remain <= load_ticks;
      end else if (armed && tick) begin
         remain <= remain - 1'b1;
         if (remain == CNT_W'(1)) armed <= 1'b0;
      end
   end

   // R3: a zero interval never arms the counter
   a_r3_zero_idle: assert property (@(posedge clk) disable iff (rst)
      (load && load_ticks == '0) |=> !armed);
   // R7: the counter stops after an expiry
   a_r7_stop_after: assert property (@(posedge clk) disable iff (rst)
      expire |=> !armed);
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic rst_o
);
   localparam int HW = $clog2(HOLD + 1);
   logic [HW-1:0] left;

   generate
      if (HOLD < 1) begin : g_bad
         $error("wdog_rst_stretch: HOLD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)              left <= '0;
      else if (start)       left <= HW'(HOLD);
      else if (left != '0)  left <= left - 1'b1;
   end
   assign rst_o = (left != '0);

   // R8: the reset output rises on the edge that starts it
   a_r8_start_high: assert property (@(posedge clk) disable iff (rst)
      start |=> rst_o);
   a_r8_hold_bound: assert property (@(posedge clk) disable iff (rst)
      rst_o |-> (left <= HW'(HOLD)));
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
   import wdog_pkg::*;
#(
   parameter int TICK_DIV = 15_625_000,
   parameter int RST_HOLD = 16
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [1:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       wd_timeout,
   output logic       wd_irq,
   output logic       sys_rst_o
);
   localparam int CENT_BIT = 6;

   generate
      if (CTL_W != 8) begin : g_bad_w
         $error("wdog_steer: control layout must fill one byte");
      end
   endgenerate

   wdog_ctl_t ctl_q;
   logic      flag_q, cent_q, irq_q;
   logic      ctl_wr, ctl_rd, load, tick, expire, hard_exp;
   wdog_ctl_t load_val;

   assign ctl_wr   = wr_en && (addr == REG_CTL);
   assign ctl_rd   = rd_en && (addr == REG_CTL) && !ctl_wr;
   assign load     = ctl_wr || ctl_rd;
   assign load_val = ctl_wr ? wdog_ctl_t'(wdata) : ctl_q;
   assign hard_exp = expire && ctl_q.steer;

   wdog_tick_div #(.DIV(TICK_DIV)) u_div (
      .clk(clk), .rst(rst), .restart(load), .tick(tick));

   wdog_countdown u_cnt (
      .clk(clk), .rst(rst), .load(load), .load_ticks(ticks_of(load_val)),
      .tick(tick), .expire(expire));

   wdog_rst_stretch #(.HOLD(RST_HOLD)) u_hold (
      .clk(clk), .rst(rst), .start(hard_exp), .rst_o(sys_rst_o));

   always_ff @(posedge clk) begin
      if (rst) begin
         ctl_q  <= '0;
         flag_q <= 1'b0;
         cent_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wr_en && addr == REG_AUX) cent_q <= wdata[CENT_BIT];
         if (ctl_wr) begin
            ctl_q  <= wdog_ctl_t'(wdata);
            flag_q <= 1'b0;
         end else if (expire) begin
            flag_q <= 1'b1;
            if (ctl_q.steer) begin
               ctl_q  <= '0;
               cent_q <= 1'b0;
            end else begin
               irq_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rdata = 8'h00;
      case (wdog_reg_e'(addr))
         REG_CTL:  rdata = ctl_q;
         REG_STAT: rdata = {flag_q, 7'b0};
         REG_AUX:  rdata[CENT_BIT] = cent_q;
         default:  rdata = 8'h00;
      endcase
   end

   assign wd_timeout = flag_q;
   assign wd_irq     = irq_q;

   // R4: a control write leaves the flag clear
   a_r4_wr_clears_flag: assert property (@(posedge clk) disable iff (rst)
      ctl_wr |=> !wd_timeout);
   // R6: the flag is sticky until a control write
   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (wd_timeout && !ctl_wr) |=> wd_timeout);
   // R7: the interrupt is a single-cycle pulse
   a_r7_irq_single: assert property (@(posedge clk) disable iff (rst)
      wd_irq |=> !wd_irq);
   // R8: a reset-mode expiry clears control and gives no interrupt
   a_r8_hard_clears: assert property (@(posedge clk) disable iff (rst)
      hard_exp |=> (ctl_q == '0 && !wd_irq && !cent_q));
endmodule

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb_top;
   localparam int DIV  = 4;
   localparam int HOLD = 5;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       wd_timeout, wd_irq, sys_rst_o;

   int errors = 0, checks = 0, irq_cnt = 0;

   always #2 clk = ~clk;   // 250 MHz

   wdog_steer #(.TICK_DIV(DIV), .RST_HOLD(HOLD)) dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .wd_timeout(wd_timeout),
      .wd_irq(wd_irq), .sys_rst_o(sys_rst_o));

   always @(posedge clk) if (!rst && wd_irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a negedge; the next posedge takes the access.
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int ticks(input logic [7:0] v);
      return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
   endfunction

   // Checks flag low one cycle before the expiry edge and high on it.
   task automatic expect_expiry(input string req, input int cyc);
      idle(cyc - 1);
      chk(req, wd_timeout, 1'b0);
      idle(1);
      chk(req, wd_timeout, 1'b1);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(2'd1, d); chk("R1 status", d, 8'h00);
      rd(2'd2, d); chk("R1 aux", d, 8'h00);
      rd(2'd0, d); chk("R1 ctl", d, 8'h00);
      chk("R1 irq", wd_irq, 1'b0);
      chk("R1 sysrst", sys_rst_o, 1'b0);
      idle(100);
      chk("R1 no expiry", wd_timeout, 1'b0);
   endtask

   task automatic t_irq_mode(input logic [7:0] v);
      int base;
      logic [7:0] d;
      wr(2'd0, v);
      base = irq_cnt;
      expect_expiry("R2 interval", ticks(v) * DIV);
      chk("R7 irq pulse", wd_irq, 1'b1);
      chk("R7 no sysrst", sys_rst_o, 1'b0);
      idle(1);
      chk("R7 irq one cycle", wd_irq, 1'b0);
      idle(60);
      chk("R7 stopped after expiry", irq_cnt - base, 1);
      rd(2'd1, d); chk("R6 status bit7", d, 8'h80);
      chk("R6 flag sticky", wd_timeout, 1'b1);
   endtask

   task automatic t_disabled(input logic [7:0] v);
      int base;
      wr(2'd0, v);
      chk("R4 write clears flag", wd_timeout, 1'b0);
      base = irq_cnt;
      idle(400);
      chk("R3 no expiry", wd_timeout, 1'b0);
      chk("R3 no irq", irq_cnt - base, 0);
   endtask

   task automatic t_read_restart();
      logic [7:0] d;
      wr(2'd0, 8'h0C);          // RES=0, M=3 -> 3 ticks
      idle(7);
      rd(2'd0, d);
      chk("R5 read value", d, 8'h0C);
      expect_expiry("R5 read restarts", 3 * DIV);
   endtask

   task automatic t_write_restart();
      wr(2'd0, 8'h0C);
      idle(8);
      wr(2'd0, 8'h04);          // RES=0, M=1 -> 1 tick
      expect_expiry("R4 write restarts", 1 * DIV);
   endtask

   task automatic t_collision();
      wr(2'd0, 8'h04);
      idle(DIV - 1);
      wr(2'd0, 8'h0C);          // lands on the expiry edge
      chk("R10 write wins", wd_timeout, 1'b0);
      expect_expiry("R10 new count", 3 * DIV);
   endtask

   task automatic t_hard_mode();
      logic [7:0] d;
      int base, width;
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk("R9 aux bit6 only", d, 8'h40);
      base = irq_cnt;
      wr(2'd0, 8'h84);          // steer=1, M=1, RES=0
      expect_expiry("R8 interval", 1 * DIV);
      width = 0;
      while (sys_rst_o && width < 100) begin
         width++;
         idle(1);
      end
      chk("R8 reset width", width, HOLD);
      chk("R8 no irq", irq_cnt - base, 0);
      rd(2'd0, d); chk("R8 ctl cleared", d, 8'h00);
      rd(2'd2, d); chk("R8 century cleared", d, 8'h00);
      wr(2'd1, 8'h00);
      rd(2'd1, d); chk("R9 status write ignored", d, 8'h80);
      idle(40);
      chk("R8 stays idle", sys_rst_o, 1'b0);
   endtask

   initial begin
      idle(3);
      rst = 1'b0;
      idle(1);
      t_reset();
      t_irq_mode(8'h05);        // 4 ticks
      t_irq_mode(8'h0A);        // 32 ticks
      t_irq_mode(8'h0C);        // 3 ticks
      t_disabled(8'h00);
      t_disabled(8'h03);        // M=0, RES=3
      t_read_restart();
      t_write_restart();
      t_collision();
      t_hard_mode();
      t_irq_mode(8'h7F);        // largest interval
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: bench timed out");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule